// File: doc/BRIEF.md
# Three-Phase Sine Duty Modulator

This block produces three duty-cycle words that trace sine waves spaced a third of a cycle apart. A downstream PWM stage drives the half-bridges of a three-phase inverter from them. One electrical cycle is divided into a ring of phase steps. A programmable divider sets how many clock cycles each step lasts, and this sets the output frequency. All three phases read one shared phase index, each with a fixed offset, from a signed sine table that is computed when the design is elaborated.

Each table sample is scaled about mid-scale by an integer amplitude factor. The result is then clamped to a safe window, so the power stage never sees duties where dead-time insertion and bootstrap refresh would distort the output. On every phase step the three new duties appear together with a single-cycle strobe. Between strobes the duties hold their values.

Top module: `sine3_duty_gen`

## Requirements
- R1: The phase index steps through 256 values, 0 to 255, and wraps back to 0 after 255. The duties at the 257th strobe therefore equal those at the first.
- R2: When the divider value D holds steady, a phase step happens every D+1 clock cycles. A step is taken whenever the internal wait count is greater than or equal to the divider input, so lowering the divider takes effect at once.
- R3: The sine sample for index i is computed as follows. Let k = i mod 128, p = k·(128−k) and den = 81920 − 4p. The magnitude is m = floor((2032·p + floor(den/2)) / den), which lies in the range 0 to 127. The sample is +m for i < 128 and −m otherwise.
- R4: Output A reads the table at the base index. Output B reads it at base+85 and output C at base+171, both modulo 256.
- R5: The unclamped duty is 512 + floor(sample·4·amp / 256). An amplitude of 256 gives full scale, equal to (sample+128)·4, and an amplitude of 0 gives 512.
- R6: Every duty is clamped into the range [16, 1007].
- R7: The three duties and the strobe change in the same cycle. The strobe is high for one cycle per step, two clock edges after the edge that takes the step. The duties hold their values between strobes.
- R8: A synchronous active-high reset sets all duties to 512 and the strobe to 0, and restarts the phase. The first step after reset emits index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| div_i | input | 16 | Divider value: clock cycles per phase step, minus one |
| amp_i | input | 9 | Amplitude factor, 256 = full scale |
| duty_a_o | output | 10 | Phase A duty (0 degrees) |
| duty_b_o | output | 10 | Phase B duty (120 degrees) |
| duty_c_o | output | 10 | Phase C duty (240 degrees) |
| strobe_o | output | 1 | One-cycle pulse when new duties are valid |

## Verification
The hardest case to reach is a full wrap of the phase ring with the amplitude at or above full scale. Only that case shows the index rolling over and both clamp limits being hit. The stimulus sets the divider to zero so that a step happens every cycle, and holds it there for more than 256 strobes. Midway through a long step, the stimulus also lowers the divider below the running wait count, to exercise the greater-or-equal comparison. A second reset while the phase is moving then checks that the phase restarts at index 0 and that the offset phases read the expected samples.

// File: rtl/tsm_pkg.sv
package tsm_pkg;

  // Integer sine approximation over a half period of `half` steps,
  // peak value `peak`, rounded to nearest.
  function automatic int tsm_sine(input int idx, input int half, input int peak);
    int k;
    int p;
    int den;
    int mag;
    k   = idx % half;
    p   = k * (half - k);
    den = 5 * half * half - 4 * p;
    mag = (peak * 16 * p + den / 2) / den;
    return (idx < half) ? mag : -mag;
  endfunction

endpackage

// File: rtl/tsm_step_gen.sv
module tsm_step_gen #(
  parameter int DIV_W = 16,
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div_i,
  output logic             step_o,
  output logic [IDX_W-1:0] idx_o
);

  logic [DIV_W-1:0] wait_cnt;
  logic [IDX_W-1:0] base;

  always_ff @(posedge clk) begin
    if (rst) begin
      wait_cnt <= '0;
      base     <= '0;
      step_o   <= 1'b0;
      idx_o    <= '0;
    end else if (wait_cnt >= div_i) begin
      wait_cnt <= '0;
      step_o   <= 1'b1;
      idx_o    <= base;
      base     <= base + 1'b1;
    end else begin
      wait_cnt <= wait_cnt + 1'b1;
      step_o   <= 1'b0;
    end
  end

  AST_INDEX_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    step_o |-> (base == IDX_W'(idx_o + 1'b1))); // R1

  AST_STEP_GAP: assert property (@(posedge clk) disable iff (rst)
    (step_o && div_i != '0) |=> !step_o); // R2

endmodule

// File: rtl/tsm_sine_rom.sv
module tsm_sine_rom
  import tsm_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int SAMP_W = 8,
  parameter int OFFSET = 0
) (
  input  logic                     clk,
  input  logic                     en,
  input  logic [IDX_W-1:0]         idx_i,
  output logic signed [SAMP_W-1:0] samp_o
);

  localparam int DEPTH = 1 << IDX_W;
  localparam int HALF  = DEPTH / 2;
  localparam int PEAK  = (1 << (SAMP_W - 1)) - 1;

  logic signed [SAMP_W-1:0] mem [DEPTH];
  logic [IDX_W-1:0]         addr;

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      mem[i] = SAMP_W'(tsm_sine(i, HALF, PEAK));
    end
  end

  assign addr = idx_i + IDX_W'(OFFSET);

  always_ff @(posedge clk) begin
    if (en) samp_o <= mem[addr];
  end

endmodule

// File: rtl/tsm_duty_scale.sv
module tsm_duty_scale #(
  parameter int SAMP_W   = 8,
  parameter int AMP_W    = 9,
  parameter int AMP_FRAC = 8,
  parameter int DUTY_W   = 10,
  parameter int DUTY_LO  = 16,
  parameter int DUTY_HI  = 1007
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     vld_i,
  input  logic signed [SAMP_W-1:0] samp_i,
  input  logic [AMP_W-1:0]         amp_i,
  output logic [DUTY_W-1:0]        duty_o
);

  localparam int PROD_W = SAMP_W + AMP_W + 4;
  localparam logic signed [PROD_W-1:0] MID = PROD_W'(1 << (DUTY_W - 1));
  localparam logic signed [PROD_W-1:0] LO  = PROD_W'(DUTY_LO);
  localparam logic signed [PROD_W-1:0] HI  = PROD_W'(DUTY_HI);

  logic signed [PROD_W-1:0] s_ext;
  logic signed [PROD_W-1:0] a_ext;
  logic signed [PROD_W-1:0] prod;
  logic signed [PROD_W-1:0] level;
  logic [DUTY_W-1:0]        clamped;

  always_comb begin
    s_ext = {{(PROD_W - SAMP_W){samp_i[SAMP_W-1]}}, samp_i};
    a_ext = {{(PROD_W - AMP_W){1'b0}}, amp_i};
    prod  = (s_ext * a_ext) <<< 2;
    level = MID + (prod >>> AMP_FRAC);
    if (level < LO)      clamped = DUTY_W'(DUTY_LO);
    else if (level > HI) clamped = DUTY_W'(DUTY_HI);
    else                 clamped = level[DUTY_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)        duty_o <= MID[DUTY_W-1:0];
    else if (vld_i) duty_o <= clamped;
  end

  AST_DUTY_RANGE: assert property (@(posedge clk) disable iff (rst)
    (duty_o >= DUTY_W'(DUTY_LO)) && (duty_o <= DUTY_W'(DUTY_HI))); // R6

  AST_DUTY_HOLD: assert property (@(posedge clk) disable iff (rst)
    !vld_i |=> $stable(duty_o)); // R7

endmodule

// File: rtl/sine3_duty_gen.sv
module sine3_duty_gen #(
  parameter int DIV_W   = 16,
  parameter int AMP_W   = 9,
  parameter int DUTY_W  = 10,
  parameter int IDX_W   = 8,
  parameter int SAMP_W  = 8,
  parameter int DUTY_LO = 16,
  parameter int DUTY_HI = 1007
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DIV_W-1:0]  div_i,
  input  logic [AMP_W-1:0]  amp_i,
  output logic [DUTY_W-1:0] duty_a_o,
  output logic [DUTY_W-1:0] duty_b_o,
  output logic [DUTY_W-1:0] duty_c_o,
  output logic              strobe_o
);

  localparam int STEPS  = 1 << IDX_W;
  localparam int PHASES = 3;

  logic             step;
  logic [IDX_W-1:0] idx;
  logic             samp_vld;
  logic [DUTY_W-1:0] duty_w [PHASES];

  tsm_step_gen #(.DIV_W(DIV_W), .IDX_W(IDX_W)) u_step (
    .clk(clk), .rst(rst), .div_i(div_i), .step_o(step), .idx_o(idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      samp_vld <= 1'b0;
      strobe_o <= 1'b0;
    end else begin
      samp_vld <= step;
      strobe_o <= samp_vld;
    end
  end

  for (genvar g = 0; g < PHASES; g++) begin : g_phase
    // offset rounded to the nearest step of g thirds of a cycle
    localparam int OFF = (STEPS * g * 2 + PHASES) / (2 * PHASES);
    logic signed [SAMP_W-1:0] samp;

    tsm_sine_rom #(.IDX_W(IDX_W), .SAMP_W(SAMP_W), .OFFSET(OFF)) u_rom (
      .clk(clk), .en(step), .idx_i(idx), .samp_o(samp)
    );

    tsm_duty_scale #(
      .SAMP_W(SAMP_W), .AMP_W(AMP_W), .AMP_FRAC(8), .DUTY_W(DUTY_W),
      .DUTY_LO(DUTY_LO), .DUTY_HI(DUTY_HI)
    ) u_scale (
      .clk(clk), .rst(rst), .vld_i(samp_vld), .samp_i(samp),
      .amp_i(amp_i), .duty_o(duty_w[g])
    );
  end

  assign duty_a_o = duty_w[0];
  assign duty_b_o = duty_w[1];
  assign duty_c_o = duty_w[2];

  AST_STROBE_LATENCY: assert property (@(posedge clk) disable iff (rst)
    strobe_o == $past(step, 2)); // R7

  AST_STROBE_SOURCE: assert property (@(posedge clk) disable iff (rst)
    $rose(strobe_o) |-> $past(samp_vld)); // R7

endmodule

// File: tb/sine3_duty_gen_test.sv
module sine3_duty_gen_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] div_i = '0;
  logic [8:0]  amp_i = 9'd256;
  logic [9:0]  duty_a_o, duty_b_o, duty_c_o;
  logic        strobe_o;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  sine3_duty_gen uut (
    .clk(clk), .rst(rst), .div_i(div_i), .amp_i(amp_i),
    .duty_a_o(duty_a_o), .duty_b_o(duty_b_o), .duty_c_o(duty_c_o),
    .strobe_o(strobe_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // R3 sample formula
  function automatic int ref_sine(input int i);
    int k, p, den, m;
    k   = i % 128;
    p   = k * (128 - k);
    den = 81920 - 4 * p;
    m   = (2032 * p + den / 2) / den;
    if (i >= 128) m = -m;
    return m;
  endfunction

  // R5 scaling, R6 clamp
  function automatic int ref_duty(input int i, input int amp);
    int d;
    d = 512 + ((ref_sine(i % 256) * 4 * amp) >>> 8);
    if (d < 16) d = 16;
    if (d > 1007) d = 1007;
    return d;
  endfunction

  // cycle-by-cycle reference model
  int  cyc = 0;
  int  wait_n = 0;
  int  base_n = 0;
  int  q_idx[$];
  int  q_due[$];
  int  exp_a = 512, exp_b = 512, exp_c = 512;
  bit  exp_stb = 1'b0;
  bit  started = 1'b0;

  always @(posedge clk) begin
    cyc++;
    started = 1'b1;
    if (rst) begin
      wait_n = 0; base_n = 0;
      q_idx.delete(); q_due.delete();
      exp_a = 512; exp_b = 512; exp_c = 512;
      exp_stb = 1'b0;
    end else begin
      exp_stb = 1'b0;
      if (q_due.size() > 0 && q_due[0] == cyc) begin
        int ix;
        ix = q_idx.pop_front();
        void'(q_due.pop_front());
        exp_a = ref_duty(ix, int'(amp_i));
        exp_b = ref_duty(ix + 85, int'(amp_i));
        exp_c = ref_duty(ix + 171, int'(amp_i));
        exp_stb = 1'b1;
      end
      if (wait_n >= int'(div_i)) begin
        q_idx.push_back(base_n);
        q_due.push_back(cyc + 2);
        base_n = (base_n + 1) % 256;
        wait_n = 0;
      end else begin
        wait_n++;
      end
    end
  end

  // comparison and step-spacing monitor
  int ncyc = 0;
  int last_stb = 0;
  int last_gap = 0;

  always @(negedge clk) begin
    ncyc++;
    if (strobe_o) begin
      last_gap = ncyc - last_stb;
      last_stb = ncyc;
    end
    if (started) begin
      chk(strobe_o == exp_stb, "R7 strobe", int'(strobe_o), int'(exp_stb));
      chk(int'(duty_a_o) == exp_a, "R3 R4 R5 R6 duty A", int'(duty_a_o), exp_a);
      chk(int'(duty_b_o) == exp_b, "R3 R4 R5 R6 duty B", int'(duty_b_o), exp_b);
      chk(int'(duty_c_o) == exp_c, "R3 R4 R5 R6 duty C", int'(duty_c_o), exp_c);
    end
  end

  task automatic wait_strobe();
    do @(negedge clk); while (!strobe_o);
  endtask

  initial begin
    int first_a, dmin, dmax;
    repeat (5) @(negedge clk);
    // R8 reset state
    chk(duty_a_o == 10'd512, "R8 reset duty A", int'(duty_a_o), 512);
    chk(duty_b_o == 10'd512, "R8 reset duty B", int'(duty_b_o), 512);
    chk(duty_c_o == 10'd512, "R8 reset duty C", int'(duty_c_o), 512);
    chk(strobe_o == 1'b0, "R8 reset strobe", int'(strobe_o), 0);
    rst = 1'b0;

    // R1 wrap and R6 limits at full amplitude, one step per cycle
    wait_strobe();
    first_a = int'(duty_a_o);
    chk(first_a == 512, "R8 first index", first_a, 512);
    dmin = 1023; dmax = 0;
    for (int n = 0; n < 256; n++) begin
      wait_strobe();
      if (int'(duty_a_o) < dmin) dmin = int'(duty_a_o);
      if (int'(duty_a_o) > dmax) dmax = int'(duty_a_o);
    end
    chk(int'(duty_a_o) == first_a, "R1 wrap", int'(duty_a_o), first_a);
    chk(dmin == 16, "R6 low clamp", dmin, 16);
    chk(dmax == 1007, "R6 high clamp", dmax, 1007);

    // R2 step spacing
    div_i = 16'd3; amp_i = 9'd128;
    repeat (30) @(negedge clk);
    chk(last_gap == 4, "R2 gap div=3", last_gap, 4);
    div_i = 16'd9;
    repeat (60) @(negedge clk);
    chk(last_gap == 10, "R2 gap div=9", last_gap, 10);

    // R5 zero amplitude
    amp_i = 9'd0; div_i = 16'd1;
    repeat (20) @(negedge clk);
    chk(duty_a_o == 10'd512 && duty_b_o == 10'd512 && duty_c_o == 10'd512,
        "R5 zero amplitude", int'(duty_a_o), 512);

    // overdriven amplitude, then divider lowered mid-step
    amp_i = 9'd511;
    repeat (100) @(negedge clk);
    amp_i = 9'd200; div_i = 16'd40;
    repeat (25) @(negedge clk);
    div_i = 16'd2;
    repeat (40) @(negedge clk);
    chk(last_gap == 3, "R2 gap after lowering", last_gap, 3);
    div_i = 16'd1000;
    repeat (3100) @(negedge clk);

    // R8 restart and R4 offsets
    rst = 1'b1; amp_i = 9'd256; div_i = 16'd5;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    wait_strobe();
    chk(duty_a_o == 10'd512, "R8 restart index 0", int'(duty_a_o), 512);
    chk(duty_b_o == 10'd952, "R4 offset 85", int'(duty_b_o), 952);
    chk(duty_c_o == 10'd72, "R4 offset 171", int'(duty_c_o), 72);
    repeat (20) @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule